// File: doc/BRIEF.md
# Serial Audio Stereo Receiver

This block turns a two-channel serial audio stream into parallel sample words that a host picks up from a single holding register. It takes a bit clock, a word-select line and a serial data line, all asynchronous to the system clock. These inputs are synchronised and oversampled, and the block acts on each rising bit-clock edge. The data line can be replaced by a loop-back line from a local transmitter, so the pair can be tested without external wiring.

Two framing conventions are supported: standard (word-select low means left, MSB one bit after the word-select edge) and left-justified (word-select high means left, MSB on the edge bit). A 3-bit length code selects the sample width. Two of its values pack a left/right pair into one word. A mono switch delivers only left samples. When a sample is delivered, the ready flag rises; a read strobe lowers it. A sample that completes while ready is still high raises an overrun summary flag and the flag of the channel that lost data. Software can set or clear each of these flags with strobes.

Top module: `sar_rx_top`

## Requirements
- R1: After reset, ready, the summary overrun flag, both channel overrun flags and the enabled status are 0, and the holding word is zero.
- R2: A pulse on `rx_on_i` enables the receiver and a pulse on `rx_off_i` disables it. When both pulse together, disable wins. `rx_active_o` shows the state. A disabled receiver delivers no samples.
- R3: In left-justified framing (`fmt_lj_i`=1), word-select high marks the left slot. The first bit sampled after a word-select change is the MSB of the new slot.
- R4: In standard framing (`fmt_lj_i`=0), word-select low marks the left slot. The MSB is the bit sampled one bit-clock period after the edge at which the word-select change is first seen.
- R5: `len_code_i` selects the sample width: 0→32, 1→24, 2→20, 3→18, 4→16, 5→16 packed, 6→8, 7→8 packed. Samples are delivered right-aligned with zeros above. Bits in a slot beyond the sample width are ignored.
- R6: With code 5, the left 16-bit sample and the following right 16-bit sample form one word: left in bits 15:0, right in bits 31:16. Ready rises only once the right sample completes.
- R7: With code 7, the left 8-bit sample lands in bits 7:0 and the right sample in bits 15:8. Bits 31:16 are zero.
- R8: Every delivery loads the holding word and sets `rdy_o`. A `hold_rd_i` pulse clears `rdy_o` in the following cycle.
- R9: A delivery while `rdy_o` is already set, with no read in that cycle, overwrites the holding word. It also sets `ovr_o` and one bit of `chovr_o`: bit 0 for a left sample, bit 1 for a right sample. Packed words count as right.
- R10: `ovr_clr_i`/`ovr_set_i` clear or set the summary flag. `chovr_clr_i`/`chovr_set_i` clear or set each channel flag per bit. A set in the same cycle as a clear wins.
- R11: With `mono_i`=1, only left samples are delivered; right samples are discarded and cause no overrun.
- R12: With `loop_en_i`=1, data is taken from `loop_sd_i` and `sd_i` is ignored. With `loop_en_i`=0 the reverse holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Word-select / channel line |
| sd_i | input | 1 | External serial data |
| loop_sd_i | input | 1 | Serial data from a local transmitter |
| fmt_lj_i | input | 1 | 1 = left-justified framing, 0 = standard framing |
| len_code_i | input | 3 | Sample width / packing code |
| mono_i | input | 1 | Deliver left samples only |
| loop_en_i | input | 1 | Select loop-back data |
| rx_on_i | input | 1 | Enable strobe |
| rx_off_i | input | 1 | Disable strobe |
| hold_rd_i | input | 1 | Holding word consumed |
| ovr_clr_i | input | 1 | Clear summary overrun |
| ovr_set_i | input | 1 | Set summary overrun |
| chovr_clr_i | input | 2 | Clear per-channel overrun (bit 0 left, bit 1 right) |
| chovr_set_i | input | 2 | Set per-channel overrun |
| rx_active_o | output | 1 | Receiver enabled |
| rdy_o | output | 1 | Holding word valid |
| hold_o | output | 32 | Holding word |
| ovr_o | output | 1 | Summary overrun |
| chovr_o | output | 2 | Per-channel overrun |

## Verification
The bench pads every slot beyond the sample width with ones. A design that kept shifting past the width, or that did not zero the upper bits, shows ones or a shifted value in the holding word.

Both framings are driven, and the word-select edge sits one bit ahead of the data in standard framing. A design that mixed up the channel polarity or the one-bit offset swaps the channels or loses the MSB.

The packed modes are checked for lane order and for ready staying low after the left half. Overrun is provoked first on the right channel and then on the left, to catch an inverted channel bit. Set/clear collisions, mono discard and loop-back pin selection are checked by watching the outputs after each stimulus.

// File: rtl/sar_pkg.sv
package sar_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned CNT_W  = $clog2(WORD_W + 1);

   typedef enum logic [2:0] {
      LEN32  = 3'd0,
      LEN24  = 3'd1,
      LEN20  = 3'd2,
      LEN18  = 3'd3,
      LEN16  = 3'd4,
      LEN16P = 3'd5,
      LEN8   = 3'd6,
      LEN8P  = 3'd7
   } len_code_e;

   // number of bits carried by one sample for a given length code
   function automatic logic [CNT_W-1:0] len_bits(input logic [2:0] code);
      logic [CNT_W-1:0] r;
      case (code)
         LEN32:         r = CNT_W'(32);
         LEN24:         r = CNT_W'(24);
         LEN20:         r = CNT_W'(20);
         LEN18:         r = CNT_W'(18);
         LEN16, LEN16P: r = CNT_W'(16);
         default:       r = CNT_W'(8);
      endcase
      return r;
   endfunction

   function automatic logic is_packed(input logic [2:0] code);
      return (code == LEN16P) || (code == LEN8P);
   endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
   parameter int unsigned N_SIG  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SIG-1:0] d_i,
   output logic [N_SIG-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sar_sync: STAGES must be at least 2");
   end
   if (N_SIG < 1) begin : g_bad_width
      $error("sar_sync: N_SIG must be at least 1");
   end

   logic [STAGES-1:0][N_SIG-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sar_frame.sv
module sar_frame
   import sar_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              bit_stb_i,
   input  logic              ws_i,
   input  logic              sd_i,
   input  logic              fmt_lj_i,
   input  logic [2:0]        len_code_i,
   output logic              done_o,
   output logic              done_left_o,
   output logic [WORD_W-1:0] data_o
);

   logic             ws_p1_q, ws_p2_q;
   logic             ws_eff, ws_eff_prev;
   logic             slot_start, slot_left;
   logic [CNT_W-1:0] target;
   logic [CNT_W-1:0] cnt_q;
   logic [WORD_W-1:0] shreg_q;
   logic             left_q, done_q;

   // word-select history, advanced once per bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ws_p1_q <= 1'b0;
         ws_p2_q <= 1'b0;
      end else if (bit_stb_i) begin
         ws_p1_q <= ws_i;
         ws_p2_q <= ws_p1_q;
      end
   end

   // standard framing looks one bit further back than left-justified
   assign ws_eff      = fmt_lj_i ? ws_i    : ws_p1_q;
   assign ws_eff_prev = fmt_lj_i ? ws_p1_q : ws_p2_q;
   assign slot_start  = ws_eff ^ ws_eff_prev;
   assign slot_left   = fmt_lj_i ? ws_eff : ~ws_eff;
   assign target      = len_bits(len_code_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         shreg_q <= '0;
         left_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!en_i) begin
            cnt_q <= '0;
         end else if (bit_stb_i) begin
            if (slot_start) begin
               shreg_q <= {{(WORD_W-1){1'b0}}, sd_i};
               cnt_q   <= CNT_W'(1);
               left_q  <= slot_left;
            end else if ((cnt_q != '0) && (cnt_q < target)) begin
               shreg_q <= {shreg_q[WORD_W-2:0], sd_i};
               cnt_q   <= cnt_q + CNT_W'(1);
               if (cnt_q + CNT_W'(1) == target) done_q <= 1'b1;
            end
         end
      end
   end

   assign done_o      = done_q;
   assign done_left_o = left_q;
   assign data_o      = shreg_q;

   // R2
   idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !done_q);
   // R5
   done_full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (cnt_q == target));

endmodule

// File: rtl/sar_assemble.sv
module sar_assemble
   import sar_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              done_i,
   input  logic              done_left_i,
   input  logic [WORD_W-1:0] data_i,
   input  logic [2:0]        len_code_i,
   input  logic              mono_i,
   input  logic              rd_i,
   input  logic              ovr_clr_i,
   input  logic              ovr_set_i,
   input  logic [1:0]        chovr_clr_i,
   input  logic [1:0]        chovr_set_i,
   output logic              rdy_o,
   output logic [WORD_W-1:0] hold_o,
   output logic              ovr_o,
   output logic [1:0]        chovr_o
);

   localparam int unsigned HALF_W = WORD_W / 2;

   logic              pack_mode;
   logic [HALF_W-1:0] left_q;
   logic              have_left_q;
   logic              deliver;
   logic [WORD_W-1:0] word;
   logic              lost;
   logic [1:0]        lost_ch;
   logic              rdy_q, ovr_q;
   logic [1:0]        chovr_q;
   logic [WORD_W-1:0] hold_q;

   assign pack_mode = is_packed(len_code_i) && !mono_i;

   always_comb begin
      deliver = 1'b0;
      word    = data_i;
      if (done_i) begin
         if (mono_i) begin
            deliver = done_left_i;
         end else if (pack_mode) begin
            if (!done_left_i && have_left_q) begin
               deliver = 1'b1;
               if (len_code_i == LEN16P)
                  word = {data_i[HALF_W-1:0], left_q};
               else
                  word = {{HALF_W{1'b0}}, data_i[7:0], left_q[7:0]};
            end
         end else begin
            deliver = 1'b1;
         end
      end
   end

   // a read in the same cycle as a delivery counts as having consumed the old word
   assign lost    = deliver && rdy_q && !rd_i;
   assign lost_ch = done_left_i ? 2'b01 : 2'b10;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q      <= '0;
         have_left_q <= 1'b0;
      end else if (!en_i) begin
         have_left_q <= 1'b0;
      end else if (done_i && pack_mode) begin
         have_left_q <= done_left_i;
         if (done_left_i) left_q <= data_i[HALF_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q   <= 1'b0;
         hold_q  <= '0;
         ovr_q   <= 1'b0;
         chovr_q <= '0;
      end else begin
         rdy_q   <= deliver | (rdy_q & ~rd_i);
         if (deliver) hold_q <= word;
         ovr_q   <= (ovr_q & ~ovr_clr_i) | ovr_set_i | lost;
         chovr_q <= (chovr_q & ~chovr_clr_i) | chovr_set_i | (lost ? lost_ch : 2'b00);
      end
   end

   assign rdy_o   = rdy_q;
   assign hold_o  = hold_q;
   assign ovr_o   = ovr_q;
   assign chovr_o = chovr_q;

   // R8
   deliver_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deliver |=> rdy_q);
   // R8
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !deliver) |=> !rdy_q);
   // R9
   lost_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (deliver && rdy_q && !rd_i) |=> ovr_q);
   // R10
   ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_set_i |=> ovr_q);
   // R10
   ch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chovr_set_i[1] |=> chovr_q[1]);
   // R11
   mono_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mono_i && done_i && !done_left_i && !rdy_q) |=> !rdy_q);

endmodule

// File: rtl/sar_rx_top.sv
module sar_rx_top
   import sar_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bclk_i,
   input  logic        ws_i,
   input  logic        sd_i,
   input  logic        loop_sd_i,
   input  logic        fmt_lj_i,
   input  logic [2:0]  len_code_i,
   input  logic        mono_i,
   input  logic        loop_en_i,
   input  logic        rx_on_i,
   input  logic        rx_off_i,
   input  logic        hold_rd_i,
   input  logic        ovr_clr_i,
   input  logic        ovr_set_i,
   input  logic [1:0]  chovr_clr_i,
   input  logic [1:0]  chovr_set_i,
   output logic        rx_active_o,
   output logic        rdy_o,
   output logic [31:0] hold_o,
   output logic        ovr_o,
   output logic [1:0]  chovr_o
);

   if (WORD_W != 32) begin : g_bad_word
      $error("sar_rx_top: word width must be 32");
   end

   logic              sd_sel;
   logic [2:0]        sync_q;
   logic              bclk_s, ws_s, sd_s, bclk_d_q, bit_stb;
   logic              en_q;
   logic              done, done_left;
   logic [WORD_W-1:0] data;

   assign sd_sel = loop_en_i ? loop_sd_i : sd_i;

   sar_sync #(.N_SIG(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({bclk_i, ws_i, sd_sel}),
      .q_o   (sync_q)
   );

   assign {bclk_s, ws_s, sd_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_d_q <= 1'b0;
      else        bclk_d_q <= bclk_s;
   end

   assign bit_stb = bclk_s & ~bclk_d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        en_q <= 1'b0;
      else if (rx_off_i) en_q <= 1'b0;
      else if (rx_on_i)  en_q <= 1'b1;
   end

   sar_frame u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (en_q),
      .bit_stb_i   (bit_stb),
      .ws_i        (ws_s),
      .sd_i        (sd_s),
      .fmt_lj_i    (fmt_lj_i),
      .len_code_i  (len_code_i),
      .done_o      (done),
      .done_left_o (done_left),
      .data_o      (data)
   );

   sar_assemble u_asm (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (en_q),
      .done_i      (done),
      .done_left_i (done_left),
      .data_i      (data),
      .len_code_i  (len_code_i),
      .mono_i      (mono_i),
      .rd_i        (hold_rd_i),
      .ovr_clr_i   (ovr_clr_i),
      .ovr_set_i   (ovr_set_i),
      .chovr_clr_i (chovr_clr_i),
      .chovr_set_i (chovr_set_i),
      .rdy_o       (rdy_o),
      .hold_o      (hold_o),
      .ovr_o       (ovr_o),
      .chovr_o     (chovr_o)
   );

   assign rx_active_o = en_q;

   // R2
   off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_off_i |=> !en_q);
   // R2
   on_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_on_i && !rx_off_i) |=> en_q);

endmodule

// File: tb/sim_sar_rx_top.sv
module sim_sar_rx_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk_i = 1'b0, ws_i = 1'b0, sd_i = 1'b0, loop_sd_i = 1'b0;
   logic        fmt_lj_i = 1'b1, mono_i = 1'b0, loop_en_i = 1'b0;
   logic [2:0]  len_code_i = 3'd0;
   logic        rx_on_i = 1'b0, rx_off_i = 1'b0, hold_rd_i = 1'b0;
   logic        ovr_clr_i = 1'b0, ovr_set_i = 1'b0;
   logic [1:0]  chovr_clr_i = 2'b00, chovr_set_i = 2'b00;
   logic        rx_active_o, rdy_o, ovr_o;
   logic [31:0] hold_o;
   logic [1:0]  chovr_o;

   int n_chk = 0;
   int n_err = 0;
   logic        lp = 1'b0;
   logic        mid_rdy, end_rdy;
   logic [31:0] mid_hold, end_hold;

   always #2 clk = ~clk;

   sar_rx_top u0 (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse(ref logic s);
      s = 1'b1; @(negedge clk); s = 1'b0; @(negedge clk);
   endtask

   task automatic bit_out(input logic w, input logic d);
      ws_i = w;
      if (lp) begin loop_sd_i = d; sd_i = ~d; end
      else    begin sd_i = d; loop_sd_i = ~d; end
      bclk_i = 1'b0; repeat (8) @(negedge clk);
      bclk_i = 1'b1; repeat (8) @(negedge clk);
   endtask

   // one stereo frame; slot bits beyond the sample width are driven as ones
   task automatic frame(input logic lj, input int slot, input int len,
                        input logic [31:0] lv, input logic [31:0] rv, input logic mid_read);
      if (lj) bit_out(1'b0, 1'b0);
      else begin bit_out(1'b1, 1'b0); bit_out(1'b0, 1'b0); end
      for (int k = 0; k < 2*slot; k++) begin
         int p;
         logic [31:0] v;
         logic d, w;
         p = k % slot;
         v = (k < slot) ? lv : rv;
         d = (p < len) ? v[len-1-p] : 1'b1;
         w = lj ? (k < slot) : ((k >= slot-1) && (k < 2*slot-1));
         if (k == slot) begin
            mid_rdy = rdy_o; mid_hold = hold_o;
            if (mid_read) pulse(hold_rd_i);
         end
         bit_out(w, d);
      end
      bclk_i = 1'b0;
      repeat (16) @(negedge clk);
      end_rdy = rdy_o; end_hold = hold_o;
   endtask

   task automatic t_reset();
      check("R1 rdy", 32'(rdy_o), 32'd0);
      check("R1 hold", hold_o, 32'd0);
      check("R1 ovr", 32'(ovr_o), 32'd0);
      check("R1 chovr", 32'(chovr_o), 32'd0);
      check("R1 active", 32'(rx_active_o), 32'd0);
   endtask

   task automatic t_enable();
      fmt_lj_i = 1'b1; len_code_i = 3'd4;
      frame(1'b1, 16, 16, 32'h1111, 32'h2222, 1'b1);
      check("R2 disabled no data", 32'(end_rdy), 32'd0);
      rx_on_i = 1'b1; rx_off_i = 1'b1; @(negedge clk); rx_on_i = 1'b0; rx_off_i = 1'b0;
      @(negedge clk);
      check("R2 off wins", 32'(rx_active_o), 32'd0);
      pulse(rx_on_i);
      check("R2 enabled", 32'(rx_active_o), 32'd1);
   endtask

   task automatic t_lj32();
      fmt_lj_i = 1'b1; len_code_i = 3'd0;
      frame(1'b1, 32, 32, 32'hA5C3_1E0F, 32'h1234_5678, 1'b1);
      check("R3 left ready", 32'(mid_rdy), 32'd1);
      check("R3 left word", mid_hold, 32'hA5C3_1E0F);
      check("R3 right word", end_hold, 32'h1234_5678);
      check("R8 ready after right", 32'(end_rdy), 32'd1);
      pulse(hold_rd_i);
      check("R8 read clears", 32'(rdy_o), 32'd0);
      check("R9 no overrun when read", 32'(ovr_o), 32'd0);
   endtask

   task automatic t_len(input logic lj, input logic [2:0] code, input int len,
                        input logic [31:0] lv, input logic [31:0] rv, input string tag);
      fmt_lj_i = lj; len_code_i = code;
      frame(lj, 32, len, lv, rv, 1'b1);
      check({tag, " left"}, mid_hold, lv);
      check({tag, " right"}, end_hold, rv);
      pulse(hold_rd_i);
   endtask

   task automatic t_pack();
      fmt_lj_i = 1'b1; len_code_i = 3'd5;
      frame(1'b1, 16, 16, 32'hBEEF, 32'hCAFE, 1'b0);
      check("R6 no ready after left", 32'(mid_rdy), 32'd0);
      check("R6 packed word", end_hold, 32'hCAFE_BEEF);
      pulse(hold_rd_i);
      fmt_lj_i = 1'b0; len_code_i = 3'd7;
      frame(1'b0, 32, 8, 32'h5A, 32'hC3, 1'b0);
      check("R7 no ready after left", 32'(mid_rdy), 32'd0);
      check("R7 packed word", end_hold, 32'h0000_C35A);
      pulse(hold_rd_i);
      check("R9 packed no overrun", 32'(ovr_o), 32'd0);
   endtask

   task automatic t_mono();
      fmt_lj_i = 1'b1; len_code_i = 3'd4; mono_i = 1'b1;
      frame(1'b1, 16, 16, 32'h1357, 32'h9BDF, 1'b1);
      check("R11 left delivered", mid_hold, 32'h1357);
      check("R11 right dropped", 32'(end_rdy), 32'd0);
      check("R11 hold kept", end_hold, 32'h1357);
      check("R11 no overrun", 32'(ovr_o), 32'd0);
      mono_i = 1'b0;
   endtask

   task automatic t_overrun();
      fmt_lj_i = 1'b1; len_code_i = 3'd6;
      frame(1'b1, 8, 8, 32'h11, 32'h22, 1'b0);
      check("R9 overwritten", end_hold, 32'h22);
      check("R9 summary", 32'(ovr_o), 32'd1);
      check("R9 right channel", 32'(chovr_o), 32'd2);
      frame(1'b1, 8, 8, 32'h33, 32'h44, 1'b0);
      check("R9 both channels", 32'(chovr_o), 32'd3);
      chovr_clr_i = 2'b10; @(negedge clk); chovr_clr_i = 2'b00; @(negedge clk);
      check("R10 clear right", 32'(chovr_o), 32'd1);
      pulse(ovr_clr_i);
      check("R10 clear summary", 32'(ovr_o), 32'd0);
      check("R10 channel kept", 32'(chovr_o), 32'd1);
      chovr_set_i = 2'b10; chovr_clr_i = 2'b10; @(negedge clk);
      chovr_set_i = 2'b00; chovr_clr_i = 2'b00; @(negedge clk);
      check("R10 set wins", 32'(chovr_o), 32'd3);
      pulse(ovr_set_i);
      check("R10 set summary", 32'(ovr_o), 32'd1);
      chovr_clr_i = 2'b11; ovr_clr_i = 1'b1; @(negedge clk);
      chovr_clr_i = 2'b00; ovr_clr_i = 1'b0; @(negedge clk);
      check("R10 all cleared", {30'd0, ovr_o, |chovr_o}, 32'd0);
      pulse(hold_rd_i);
   endtask

   task automatic t_loop();
      fmt_lj_i = 1'b1; len_code_i = 3'd4; lp = 1'b1; loop_en_i = 1'b1;
      frame(1'b1, 16, 16, 32'h6C39, 32'h0F81, 1'b1);
      check("R12 loop left", mid_hold, 32'h6C39);
      check("R12 loop right", end_hold, 32'h0F81);
      pulse(hold_rd_i);
      loop_en_i = 1'b0;
      frame(1'b1, 16, 16, 32'h6C39, 32'h0F81, 1'b1);
      check("R12 pin left", mid_hold, 32'h93C6);
      check("R12 pin right", end_hold, 32'hF07E);
      pulse(hold_rd_i);
      lp = 1'b0;
   endtask

   task automatic t_disable();
      pulse(rx_off_i);
      check("R2 disabled", 32'(rx_active_o), 32'd0);
      frame(1'b1, 16, 16, 32'h1234, 32'h5678, 1'b0);
      check("R2 no capture while off", 32'(end_rdy), 32'd0);
   endtask

   logic done_flag = 1'b0;

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_lj32();
      t_len(1'b0, 3'd1, 24, 32'h00AB_CDEF, 32'h0012_3456, "R4 R5 24-bit standard");
      t_len(1'b1, 3'd3, 18, 32'h0002_ABCD, 32'h0001_5A5A, "R5 18-bit");
      t_len(1'b1, 3'd2, 20, 32'h000F_0F0F, 32'h0008_0001, "R5 20-bit");
      t_len(1'b0, 3'd6, 8, 32'h0000_0081, 32'h0000_007E, "R4 R5 8-bit");
      t_pack();
      t_mono();
      t_overrun();
      t_loop();
      t_disable();
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule